// File: doc/BRIEF.md
# Prescaled Reload Countdown Timer

This block is a down-counting timer whose count rate comes from the system clock through a programmable prescaler. A prescale value P sets the length of one prescaled tick. The tick is 2·P+1 clocks long by default and 2·P+2 clocks long when the even-divide mode bit is set. A reload value R sets how many ticks one timer stage lasts, which is R+1 ticks.

There are two ways to start the timer. Software can pulse a start strobe. Software can also set the auto-arm bit, and the timer then starts on a single-cycle protocol event strobe. A stop strobe halts the timer and freezes its count. When the stop strobe and a start arrive in the same cycle, the stop wins.

While the timer runs, it counts down once per prescaled tick. When a tick arrives with the count already at zero, the block emits a one-cycle underflow pulse and loads the reload value again. The next stage then follows without a gap.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, `running` is 0, `count` is 0 and `underflow` is 0.
- R2: One prescaled tick lasts 2·P+1 clocks when `cfg_even` is 0 and 2·P+2 clocks when `cfg_even` is 1, where P is `cfg_prescale`. P ranges from 0 to 4095, so the longest tick is 8192 clocks.
- R3: A start that is accepted in a cycle makes `running` 1 and `count` equal to `cfg_reload` from the next cycle. The count then drops by one at the end of each prescaled tick.
- R4: A tick that ends with `count` at 0 reloads `cfg_reload` and raises `underflow` for one cycle. The first `underflow` appears exactly (R+1)·N cycles after the start cycle, where N is the tick length from R2. Each later stage has the same length.
- R5: `stop_stb` clears `running` from the next cycle. While the timer is stopped, `count` holds its value and `underflow` stays 0.
- R6: When `stop_stb` and a start (manual or event) arrive in the same cycle, the timer stops and does not load.
- R7: With `cfg_auto` at 1, `evt_stb` starts the timer exactly like `start_stb`. With `cfg_auto` at 0, `evt_stb` has no effect on `running` or `count`.
- R8: A start accepted while the timer is running restarts the stage: `count` loads `cfg_reload` and the prescaler begins a fresh tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prescale | input | 12 | Prescale value P |
| cfg_reload | input | 16 | Reload value R |
| cfg_even | input | 1 | 1 selects a tick of 2·P+2 clocks, 0 selects 2·P+1 |
| cfg_auto | input | 1 | 1 arms `evt_stb` as a start source |
| start_stb | input | 1 | Manual start pulse |
| stop_stb | input | 1 | Manual stop pulse, wins over any start |
| evt_stb | input | 1 | Protocol event pulse |
| count | output | 16 | Current counter value |
| running | output | 1 | Timer is counting |
| underflow | output | 1 | One-cycle pulse at the end of each stage |

## Verification
The bench measures the exact number of cycles from a start to each underflow for these combinations of P, mode and R:
- P = 0 in both modes, the shortest ticks.
- P = 169 in the default mode.
- P = 4095 in even mode, the longest tick.
- R = 0, where every tick ends a stage.

An off-by-one in the prescaler or in the stage count would show up as an interval one tick or one clock too long or too short. The bench drives stop and start in the same cycle to catch a design that reloads when it should halt. It pulses the event strobe with auto-arm off to catch a design that ignores the arm bit. It checks that a stopped timer keeps its count and stays silent. A behavioural model of the timer is compared with all three outputs on every clock, which catches a wrong count value between underflows.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        TT_NONE = 2'd0,
        TT_GO   = 2'd1,
        TT_HALT = 2'd2
    } tt_cmd_e;

    typedef struct packed {
        logic go;
        logic tick;
    } tt_step_t;

    // A halt always wins; otherwise a manual start or an armed event starts.
    function automatic tt_cmd_e tt_decode(input logic start, input logic stop,
                                          input logic evt, input logic auto_en);
        if (stop)
            return TT_HALT;
        else if (start || (evt && auto_en))
            return TT_GO;
        else
            return TT_NONE;
    endfunction

endpackage

// File: rtl/tt_control.sv
module tt_control
    import tick_timer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tt_cmd_e cmd_i,
    output logic    run_o
);
    always_ff @(posedge clk) begin
        if (rst)
            run_o <= 1'b0;
        else if (cmd_i == TT_HALT)
            run_o <= 1'b0;
        else if (cmd_i == TT_GO)
            run_o <= 1'b1;
    end

    a_r6_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == TT_HALT) |=> !run_o);

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler
    import tick_timer_pkg::*;
#(
    parameter int PSC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] prescale_i,
    input  logic             even_i,
    input  logic             run_i,
    input  tt_cmd_e          cmd_i,
    output tt_step_t         step_o
);
    localparam int PW = PSC_W + 2;

    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] last;
    logic          go;
    logic          adv;

    // Last phase index: 2P for the odd period, 2P+1 for the even one.
    assign last = {1'b0, prescale_i, 1'b0} + PW'(even_i);
    assign go   = (cmd_i == TT_GO);
    assign adv  = run_i && (cmd_i == TT_NONE);

    assign step_o.go   = go;
    assign step_o.tick = adv && (pcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || go)
            pcnt_q <= '0;
        else if (adv)
            pcnt_q <= (pcnt_q == last) ? '0 : pcnt_q + PW'(1);
    end

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        step_o.tick |=> (pcnt_q == '0));
    a_r2_bound: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (pcnt_q <= last) || go || $changed(prescale_i) || $changed(even_i));

endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             run_i,
    input  tt_step_t         step_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uf_o
);
    logic at_zero;
    assign at_zero = (cnt_o == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            uf_o  <= 1'b0;
        end else begin
            uf_o <= step_i.tick && at_zero;
            if (step_i.go)
                cnt_o <= reload_i;
            else if (step_i.tick)
                cnt_o <= at_zero ? reload_i : cnt_o - CNT_W'(1);
        end
    end

    a_r3_start_loads: assert property (@(posedge clk) disable iff (rst)
        step_i.go |=> (cnt_o == $past(reload_i)));
    a_r4_uf_reloads: assert property (@(posedge clk) disable iff (rst)
        uf_o |-> (cnt_o == $past(reload_i)));
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !step_i.go) |=> (cnt_o == $past(cnt_o)) && !uf_o);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int PSC_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PSC_W-1:0] cfg_prescale,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic             cfg_even,
    input  logic             cfg_auto,
    input  logic             start_stb,
    input  logic             stop_stb,
    input  logic             evt_stb,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             underflow
);
    tt_cmd_e  cmd;
    tt_step_t step;

    assign cmd = tt_decode(start_stb, stop_stb, evt_stb, cfg_auto);

    tt_control u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cmd),
        .run_o (running)
    );

    tt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk        (clk),
        .rst        (rst),
        .prescale_i (cfg_prescale),
        .even_i     (cfg_even),
        .run_i      (running),
        .cmd_i      (cmd),
        .step_o     (step)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .reload_i (cfg_reload),
        .run_i    (running),
        .step_i   (step),
        .cnt_o    (count),
        .uf_o     (underflow)
    );

    a_r5_uf_only_running: assert property (@(posedge clk) disable iff (rst)
        underflow |-> running);
    a_r7_unarmed_event: assert property (@(posedge clk) disable iff (rst)
        (!running && evt_stb && !cfg_auto && !start_stb) |=> !running);

endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cfg_prescale = '0;
    logic [15:0] cfg_reload = '0;
    logic        cfg_even = 1'b0;
    logic        cfg_auto = 1'b0;
    logic        start_stb = 1'b0;
    logic        stop_stb = 1'b0;
    logic        evt_stb = 1'b0;
    logic [15:0] count;
    logic        running;
    logic        underflow;

    int checks = 0;
    int fails = 0;
    bit cmp_en = 1'b0;

    // Behavioural reference state.
    bit     m_run = 1'b0;
    bit     m_uf = 1'b0;
    longint m_cnt = 0;
    longint m_el = 0;
    longint m_R = 0;
    longint m_N = 1;

    always #2 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst(rst), .cfg_prescale(cfg_prescale), .cfg_reload(cfg_reload),
        .cfg_even(cfg_even), .cfg_auto(cfg_auto), .start_stb(start_stb),
        .stop_stb(stop_stb), .evt_stb(evt_stb), .count(count),
        .running(running), .underflow(underflow)
    );

    // Model: elapsed clocks since start determine count and underflow.
    always @(posedge clk) begin
        bit go;
        go = (start_stb || (cfg_auto && evt_stb)) && !stop_stb;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_uf = 0; m_el = 0;
        end else if (stop_stb) begin
            m_run = 0; m_uf = 0;
        end else if (go) begin
            m_run = 1; m_el = 0; m_uf = 0;
            m_R = longint'(cfg_reload);
            m_N = 2 * longint'(cfg_prescale) + (cfg_even ? 2 : 1);
            m_cnt = m_R;
        end else if (m_run) begin
            m_el = m_el + 1;
            m_uf = ((m_el % ((m_R + 1) * m_N)) == 0);
            m_cnt = m_R - ((m_el / m_N) % (m_R + 1));
        end else begin
            m_uf = 0;
        end
    end

    // R3/R4/R5 model comparison on every clock.
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (longint'(count) != m_cnt || running != m_run || underflow != m_uf) begin
                fails++;
                $display("FAIL R3/R4/R5 model: count=%0d run=%0b uf=%0b expected count=%0d run=%0b uf=%0b",
                         count, running, underflow, m_cnt, m_run, m_uf);
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_stb = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
    endtask

    // Cycles from start to first and second underflow (R2, R4).
    task automatic measure(input string tag, input int p, input bit ev, input int r);
        longint n;
        longint j;
        @(negedge clk);
        cfg_prescale = 12'(p); cfg_even = ev; cfg_reload = 16'(r);
        n = 2 * p + (ev ? 2 : 1);
        pulse_start();
        j = 0;
        while (!underflow && j < 40000) begin @(negedge clk); j++; end
        check({tag, " R4 first stage"}, j, (r + 1) * n);
        check({tag, " R4 reload"}, count, r);
        j = 0;
        if (n * (r + 1) > 1) begin
            @(negedge clk); j = 1;
            check({tag, " R4 pulse width"}, underflow, 0);
            while (!underflow && j < 40000) begin @(negedge clk); j++; end
        end else begin
            @(negedge clk); j = 1;
        end
        check({tag, " R2 second stage"}, j, (r + 1) * n);
        do_stop();
    endtask

    initial begin
        longint held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 running", running, 0);
        check("R1 count", count, 0);
        check("R1 underflow", underflow, 0);
        cmp_en = 1'b1;

        measure("P0 odd", 0, 1'b0, 3);
        measure("P0 even", 0, 1'b1, 3);
        measure("P169 odd", 169, 1'b0, 2);
        measure("P5 even R0", 5, 1'b1, 0);
        measure("P0 odd R0", 0, 1'b0, 0);
        measure("P4095 even", 4095, 1'b1, 1);

        // R3: load and decrement timing with P=2 (N=5).
        @(negedge clk); cfg_prescale = 12'd2; cfg_even = 1'b0; cfg_reload = 16'd10;
        pulse_start();
        check("R3 running", running, 1);
        check("R3 loaded", count, 10);
        repeat (4) @(negedge clk);
        check("R3 before tick", count, 10);
        @(negedge clk);
        check("R3 after tick", count, 9);

        // R5: stop holds count.
        do_stop();
        held = count;
        check("R5 stopped", running, 0);
        repeat (20) @(negedge clk);
        check("R5 held", count, held);
        check("R5 no underflow", underflow, 0);

        // R8: restart while running.
        pulse_start();
        repeat (7) @(negedge clk);
        check("R8 mid", count, 9);
        @(negedge clk); cfg_reload = 16'd20; start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
        check("R8 reloaded", count, 20);
        repeat (5) @(negedge clk);
        check("R8 fresh tick", count, 19);

        // R6: stop wins over simultaneous start.
        held = count;
        @(negedge clk); stop_stb = 1'b1; start_stb = 1'b1; evt_stb = 1'b1; cfg_auto = 1'b1;
        @(negedge clk); stop_stb = 1'b0; start_stb = 1'b0; evt_stb = 1'b0; cfg_auto = 1'b0;
        check("R6 stopped", running, 0);
        check("R6 no load", count, held);

        // R7: event ignored when not armed, starts when armed.
        @(negedge clk); cfg_reload = 16'd7; evt_stb = 1'b1;
        @(negedge clk); evt_stb = 1'b0;
        check("R7 unarmed run", running, 0);
        check("R7 unarmed count", count, held);
        @(negedge clk); cfg_auto = 1'b1; evt_stb = 1'b1;
        @(negedge clk); evt_stb = 1'b0;
        check("R7 armed run", running, 1);
        check("R7 armed count", count, 7);
        repeat (50) @(negedge clk);
        do_stop();
        cfg_auto = 1'b0;
        repeat (3) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule